// File: doc/BRIEF.md
# Single-Accumulator Eight-Bit Processor Core

This block is a very small processor built around one 8-bit accumulator. It runs a program held in a 16-byte store that software cannot change while the core runs. Every transfer between registers goes over one internal 8-bit bus. Each instruction takes six clock steps. The first three steps fetch the instruction byte. The last three steps carry it out, under a 12-bit control word produced by a ring-counter controller. The core has no branches and no condition flags. The program counter only counts upward, and the only thing the core shows to the outside is its output register.

The program is written through a load port, and only while reset is held low. Once reset is released, execution starts at address 0. Execution continues until a halt instruction. From then on the core keeps every register as it is and raises the halted flag, until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and after it, until an output instruction executes, `out_val` is 0x00 and `halted` is 0.
- R2: Opcode 0x0 (upper nibble of the instruction byte) loads the accumulator with the program byte whose address is the lower nibble.
- R3: Opcode 0x1 adds the addressed byte to the accumulator, modulo 256.
- R4: Opcode 0x2 subtracts the addressed byte from the accumulator, modulo 256 (0x05 minus 0x07 gives 0xFE).
- R5: Opcode 0xE copies the accumulator to `out_val`, whatever its lower nibble holds. `out_val` changes at no other time.
- R6: Opcode 0xF, with any lower nibble, raises `halted`. After that, `halted` and `out_val` stay unchanged until reset, even if output instructions follow the halt in the store.
- R7: Every instruction, of any opcode, takes exactly six clock cycles. Each extra instruction placed ahead of the halt delays `halted` by six cycles.
- R8: Opcodes 0x3 to 0xD change neither the accumulator nor the output.
- R9: The store 07 16 2F E3 F5 A1 92 83 74 65 56 47 38 29 1A 0B, at addresses 0 to 15, ends with `out_val` = 0x0A and `halted` = 1.
- R10: Load-port writes made while reset is not held are ignored. The stored program is unchanged across a later reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| ld_en | input | 1 | Program store write strobe; takes effect only while rst_n is low |
| ld_addr | input | 4 | Program store write address |
| ld_data | input | 8 | Program store write data |
| out_val | output | 8 | Output register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench drives results past the 8-bit boundary in both directions. A core that kept a carry, or that saturated, would show the wrong byte at the output. It measures how long programs of different lengths take to halt. A controller that skipped empty steps, or gave some opcodes a different step count, would change that gap away from six cycles. It places output instructions after a halt, and opcodes with no defined function between a load and an output. A halt that did not freeze the core, or an undefined opcode that touched the accumulator, would change the output value. Finally, it writes to the load port while the core runs and then reruns the program. A store that accepted those writes would produce a different result.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int STEPS = 6;

  localparam logic [3:0] OP_LDA = 4'h0;
  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_SUB = 4'h2;
  localparam logic [3:0] OP_OUT = 4'hE;
  localparam logic [3:0] OP_HLT = 4'hF;

  // 12-bit control word
  typedef struct packed {
    logic pc_inc;   // advance program counter
    logic pc_drv;   // program counter onto bus
    logic mar_ld;   // load address register
    logic mem_drv;  // memory onto bus
    logic ir_ld;    // load instruction register
    logic ir_drv;   // operand field onto bus
    logic acc_ld;   // load accumulator
    logic acc_drv;  // accumulator onto bus
    logic sub;      // adder-subtractor subtracts
    logic alu_drv;  // adder-subtractor onto bus
    logic b_ld;     // load B register
    logic out_ld;   // load output register
  } ctrl_word_t;
endpackage

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int STEPS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  output ctrl_word_t cw,
  output logic       halted
);
  logic [STEPS-1:0] ring, ring_nxt;
  logic             halt_q, halt_nxt;

  always_comb begin
    ring_nxt = ring;
    if (!halt_q) ring_nxt = {ring[STEPS-2:0], ring[STEPS-1]};
    halt_nxt = halt_q | (ring[3] & (opcode == OP_HLT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring   <= STEPS'(1);
      halt_q <= 1'b0;
    end else begin
      ring   <= ring_nxt;
      halt_q <= halt_nxt;
    end
  end

  always_comb begin
    cw = '0;
    if (!halt_q) begin
      if (ring[0]) begin
        cw.pc_drv = 1'b1;
        cw.mar_ld = 1'b1;
      end else if (ring[1]) begin
        cw.pc_inc = 1'b1;
      end else if (ring[2]) begin
        cw.mem_drv = 1'b1;
        cw.ir_ld   = 1'b1;
      end else if (ring[3]) begin
        if (opcode == OP_LDA || opcode == OP_ADD || opcode == OP_SUB) begin
          cw.ir_drv = 1'b1;
          cw.mar_ld = 1'b1;
        end else if (opcode == OP_OUT) begin
          cw.acc_drv = 1'b1;
          cw.out_ld  = 1'b1;
        end
      end else if (ring[4]) begin
        if (opcode == OP_LDA) begin
          cw.mem_drv = 1'b1;
          cw.acc_ld  = 1'b1;
        end else if (opcode == OP_ADD || opcode == OP_SUB) begin
          cw.mem_drv = 1'b1;
          cw.b_ld    = 1'b1;
        end
      end else if (ring[5]) begin
        if (opcode == OP_ADD || opcode == OP_SUB) begin
          cw.alu_drv = 1'b1;
          cw.acc_ld  = 1'b1;
          cw.sub     = (opcode == OP_SUB);
        end
      end
    end
  end

  assign halted = halt_q;

  a_r7_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ring));
  a_r7_wrap_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (ring[STEPS-1] && !halt_q) |=> ring[0]);
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(ring)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] out_val,
  output logic          halted
);
  logic [1:0]    rst_pipe;
  logic          core_rst_n;
  ctrl_word_t    cw;
  logic [DW-1:0] bus, mem_q, acc_q, b_q, ir_q, alu_y;
  logic [AW-1:0] pc_q, pc_nxt, mar_q, mar_nxt;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  // program counter and address register
  always_comb begin
    pc_nxt  = pc_q;
    mar_nxt = mar_q;
    if (cw.pc_inc) pc_nxt  = pc_q + 1'b1;
    if (cw.mar_ld) mar_nxt = bus[AW-1:0];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      pc_q  <= pc_nxt;
      mar_q <= mar_nxt;
    end
  end

  acc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .wr_en(ld_en & ~rst_n), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_addr(mar_q), .rd_data(mem_q)
  );

  acc_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .opcode(ir_q[DW-1:DW-4]), .cw(cw), .halted(halted)
  );

  acc_alu #(.DW(DW)) u_alu (.a(acc_q), .b(b_q), .sub(cw.sub), .y(alu_y));

  // shared bus: at most one driver per step
  always_comb begin
    bus = '0;
    if (cw.pc_drv)  bus = DW'(pc_q);
    if (cw.mem_drv) bus = mem_q;
    if (cw.ir_drv)  bus = DW'(ir_q[AW-1:0]);
    if (cw.acc_drv) bus = acc_q;
    if (cw.alu_drv) bus = alu_y;
  end

  // byte-wide registers loaded from the bus
  localparam int NREG = 4;
  logic [NREG-1:0] reg_en;
  logic [DW-1:0]   reg_q [NREG];
  assign reg_en = {cw.out_ld, cw.b_ld, cw.acc_ld, cw.ir_ld};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    acc_reg #(.W(DW)) u_reg (
      .clk(clk), .rst_n(core_rst_n), .en(reg_en[g]), .d(bus), .q(reg_q[g])
    );
  end

  assign ir_q    = reg_q[0];
  assign acc_q   = reg_q[1];
  assign b_q     = reg_q[2];
  assign out_val = reg_q[3];

  a_r5_single_driver: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({cw.pc_drv, cw.mem_drv, cw.ir_drv, cw.acc_drv, cw.alu_drv}));
  a_r5_out_only_on_op: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(out_val) |-> $past(cw.out_ld));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> ($stable(out_val) && $stable(acc_q) && $stable(pc_q)));
  a_r7_pc_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    cw.pc_inc |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] out_val;
  logic       halted;
  int vectors = 0;
  int fails = 0;
  logic [7:0] prog [16];

  always #10ns clk = ~clk;

  acc_core i_acc_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .out_val(out_val), .halted(halted)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'hF0;
  endtask

  task automatic load_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  // releases reset, returns cycles until halted
  task automatic run(output int cyc);
    cyc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("watchdog run", 8'h00, 8'h01);
  endtask

  task automatic t_reset();
    clear_prog();
    load_prog();
    chk("R1 out in reset", out_val, 8'h00);
    chk("R1 halted in reset", {7'b0, halted}, 8'h00);
  endtask

  task automatic t_selfcheck();
    int c;
    logic [7:0] p [16] = '{8'h07,8'h16,8'h2F,8'hE3,8'hF5,8'hA1,8'h92,8'h83,
                           8'h74,8'h65,8'h56,8'h47,8'h38,8'h29,8'h1A,8'h0B};
    for (int i = 0; i < 16; i++) prog[i] = p[i];
    load_prog();
    run(c);
    chk("R9 self-check out", out_val, 8'h0A);
    chk("R9 self-check halted", {7'b0, halted}, 8'h01);
  endtask

  task automatic t_add_wrap();
    int c;
    clear_prog();
    prog[0] = 8'h08; prog[1] = 8'h19; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[8] = 8'hF0; prog[9] = 8'h20;
    load_prog();
    run(c);
    chk("R3 add wraps", out_val, 8'h10);
  endtask

  task automatic t_sub_wrap();
    int c;
    clear_prog();
    prog[0] = 8'h08; prog[1] = 8'h29; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[8] = 8'h05; prog[9] = 8'h07;
    load_prog();
    run(c);
    chk("R4 sub wraps", out_val, 8'hFE);
  endtask

  task automatic t_load_out();
    int c;
    clear_prog();
    prog[0] = 8'h0A; prog[1] = 8'hE7; prog[2] = 8'h0B; prog[3] = 8'hF9;
    prog[10] = 8'h5C; prog[11] = 8'h33;
    load_prog();
    run(c);
    chk("R2 load then R5 out", out_val, 8'h5C);
  endtask

  task automatic t_halt_freeze();
    int c;
    clear_prog();
    prog[0] = 8'h0A; prog[1] = 8'hE0; prog[2] = 8'hF3; prog[3] = 8'h0B;
    prog[4] = 8'hE0; prog[10] = 8'h11; prog[11] = 8'h99;
    load_prog();
    run(c);
    chk("R6 out at halt", out_val, 8'h11);
    repeat (40) @(negedge clk);
    chk("R6 out after halt", out_val, 8'h11);
    chk("R6 halted held", {7'b0, halted}, 8'h01);
  endtask

  task automatic t_undef();
    int c;
    clear_prog();
    prog[0] = 8'h0A; prog[1] = 8'h3B; prog[2] = 8'h9B; prog[3] = 8'hDB;
    prog[4] = 8'hE0; prog[5] = 8'hF0; prog[10] = 8'h42; prog[11] = 8'hFF;
    load_prog();
    run(c);
    chk("R8 undefined opcodes", out_val, 8'h42);
  endtask

  task automatic t_timing();
    int c0, c1, c2;
    clear_prog();
    load_prog();
    run(c0);
    prog[0] = 8'h0F;
    load_prog();
    run(c1);
    prog[0] = 8'h1F; prog[1] = 8'hE0; prog[2] = 8'hF0;
    load_prog();
    run(c2);
    chk("R7 one instruction", 8'(c1 - c0), 8'd6);
    chk("R7 two instructions", 8'(c2 - c0), 8'd12);
  endtask

  task automatic t_load_ignored();
    int c;
    clear_prog();
    prog[0] = 8'h0A; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[10] = 8'h3C;
    load_prog();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = 8'hE0;
      @(negedge clk);
    end
    ld_en = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 first run", out_val, 8'h3C);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out cleared by reset", out_val, 8'h00);
    run(c);
    chk("R10 rerun unchanged", out_val, 8'h3C);
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_selfcheck();
    t_add_wrap();
    t_sub_wrap();
    t_load_out();
    t_halt_freeze();
    t_undef();
    t_timing();
    t_load_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule